// File: doc/BRIEF.md
# Shared Display RAM Arbiter

This block decides, one character time at a time, whether a single RAM is driven by the processor bus or by the video refresh engine. It takes a processor memory request together with a decode saying whether the address falls in the shared display region. It also takes the video engine's access window and a character-clock enable. From these it drives the address multiplexer select, the processor acknowledge and wait lines, a gated write strobe for the RAM, and a request that blanks the video output.

The display has priority for new ownership, but a processor access that already owns the RAM is never cut short. If the display window opens during such an access, the display waits for it to finish. The screen is blanked while the display is kept waiting, because the characters fetched in that time would be wrong. Once the display has the RAM, the processor is shut out until the window closes. The blank is stretched for a configurable number of character times after the disturbed access, to give the RAM time to recover.

Requests outside the display region do not touch this RAM. They are acknowledged at once, whoever owns the RAM.

Top module: `shared_ram_arbiter`

## Requirements
- R1: After reset the RAM is free. The address select routes the processor (`addr_sel_cpu`=1), and `cpu_ack`, `cpu_wait`, `ram_we` and `vid_blank` are all 0.
- R2: With the video window closed, a display-region request (`cpu_req`=1, `cpu_hit`=1) seen at a character tick gives the processor ownership. From the next cycle `cpu_ack`=1 and `cpu_wait`=0.
- R3: Ownership and the address select change only in cycles where `char_tick` was 1. Without a tick, a pending request keeps waiting.
- R4: When the RAM is free and the video window is open at a tick, the display takes the RAM (`addr_sel_cpu`=0), even if a display-region request is pending at the same time.
- R5: A processor access that owns the RAM keeps it while `cpu_req` stays 1, even after the video window opens.
- R6: Once the display owns the RAM, display-region requests see `cpu_wait`=1 and `cpu_ack`=0 until a tick at which the window is closed.
- R7: A tick with the window closed hands the RAM to a pending display-region request.
- R8: A request outside the display region (`cpu_hit`=0) gets `cpu_ack`=1 and `cpu_wait`=0 in the same cycle, whoever owns the RAM.
- R9: `ram_we` is 1 only when `cpu_we`=1 and the processor owns the RAM for a display-region request. It is 0 while waiting and for outside requests.
- R10: `vid_blank`=1 in every cycle where the processor owns the RAM while the video window is open.
- R11: After the last tick of such a disturbed access, `vid_blank` stays 1 for exactly RECOVER_TICKS (default 2) further character ticks, then returns to 0.
- R12: `addr_sel_cpu`=1 whenever the display does not own the RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_tick | input | 1 | One-cycle character-clock enable |
| vid_window | input | 1 | Video engine needs the RAM for character fetches |
| cpu_req | input | 1 | Processor memory operation request |
| cpu_hit | input | 1 | Request address lies in the display region |
| cpu_we | input | 1 | Processor write strobe |
| addr_sel_cpu | output | 1 | Address mux select: 1 processor, 0 video |
| cpu_ack | output | 1 | Processor acknowledge |
| cpu_wait | output | 1 | Processor held off |
| ram_we | output | 1 | Gated write strobe to the RAM |
| vid_blank | output | 1 | Blank request for the video output |

## Verification
The assertions assume that a processor request stays up until it is acknowledged, and that `char_tick` is a single-cycle pulse. The bench drives every input 1 ns after a rising edge and keeps requests steady across the ticks that serve them. Windows are opened and closed only between ticks. That way each ownership change lands on a known tick, and the blank hold count can be checked one character time at a time.

// File: rtl/dra_pkg.sv
package dra_pkg;

    typedef enum logic [1:0] {
        OWN_FREE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_VID  = 2'd2
    } owner_e;

    typedef struct packed {
        logic req;
        logic hit;
        logic we;
    } cpu_bus_t;

    // Next owner at a character tick: video wins a free RAM, a running
    // processor access is never cut, video keeps the RAM until its window ends.
    function automatic owner_e owner_next(owner_e cur, logic win, cpu_bus_t bus);
        owner_e nxt;
        logic   want;
        want = bus.req && bus.hit;
        nxt  = cur;
        case (cur)
            OWN_FREE: begin
                if (win)       nxt = OWN_VID;
                else if (want) nxt = OWN_CPU;
            end
            OWN_CPU: begin
                if (!want)     nxt = win ? OWN_VID : OWN_FREE;
            end
            OWN_VID: begin
                if (!win)      nxt = want ? OWN_CPU : OWN_FREE;
            end
            default:           nxt = OWN_FREE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/dra_owner_fsm.sv
module dra_owner_fsm
    import dra_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     char_tick,
    input  logic     vid_window,
    input  cpu_bus_t bus,
    output owner_e   owner
);

    owner_e state_q;

    always_ff @(posedge clk) begin
        if (rst)            state_q <= OWN_FREE;
        else if (char_tick) state_q <= owner_next(state_q, vid_window, bus);
    end

    assign owner = state_q;

    a_r3_owner_on_tick: assert property (@(posedge clk) disable iff (rst)
        !char_tick |=> $stable(state_q));

    a_r4_video_first: assert property (@(posedge clk) disable iff (rst)
        (char_tick && state_q == OWN_FREE && vid_window) |=> state_q == OWN_VID);

    a_r5_no_abort: assert property (@(posedge clk) disable iff (rst)
        (state_q == OWN_CPU && bus.req && bus.hit) |=> state_q == OWN_CPU);

    a_r6_lockout: assert property (@(posedge clk) disable iff (rst)
        (state_q == OWN_VID && vid_window) |=> state_q == OWN_VID);

endmodule

// File: rtl/dra_blank_hold.sv
module dra_blank_hold #(
    parameter int RECOVER_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic char_tick,
    input  logic disrupt,
    output logic vid_blank
);

    localparam int CW = $clog2(RECOVER_TICKS + 1);

    logic [CW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (char_tick) begin
            if (disrupt)           hold_q <= CW'(RECOVER_TICKS);
            else if (hold_q != '0) hold_q <= hold_q - CW'(1);
        end
    end

    assign vid_blank = disrupt || (hold_q != '0);

    a_r11_hold_after: assert property (@(posedge clk) disable iff (rst)
        (char_tick && disrupt) |=> vid_blank);

    a_r11_hold_bound: assert property (@(posedge clk) disable iff (rst)
        hold_q <= CW'(RECOVER_TICKS));

endmodule

// File: rtl/dra_cpu_gate.sv
module dra_cpu_gate
    import dra_pkg::*;
(
    input  owner_e   owner,
    input  cpu_bus_t bus,
    input  logic     vid_window,
    output logic     addr_sel_cpu,
    output logic     cpu_ack,
    output logic     cpu_wait,
    output logic     ram_we,
    output logic     disrupt
);

    logic own_cpu;
    logic want;

    always_comb begin
        own_cpu      = (owner == OWN_CPU);
        want         = bus.req && bus.hit;
        addr_sel_cpu = (owner != OWN_VID);
        cpu_ack      = bus.req && (!bus.hit || own_cpu);
        cpu_wait     = want && !own_cpu;
        ram_we       = want && own_cpu && bus.we;
        disrupt      = own_cpu && vid_window;
    end

    always_comb begin
        a_r8_outside: assert (!(bus.req && !bus.hit) || (cpu_ack && !cpu_wait));
        a_r9_we_owned: assert (!ram_we || (owner == OWN_CPU && bus.hit));
        a_r6_ack_excl: assert (!(cpu_ack && cpu_wait));
    end

endmodule

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter
    import dra_pkg::*;
#(
    parameter int RECOVER_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic char_tick,
    input  logic vid_window,
    input  logic cpu_req,
    input  logic cpu_hit,
    input  logic cpu_we,
    output logic addr_sel_cpu,
    output logic cpu_ack,
    output logic cpu_wait,
    output logic ram_we,
    output logic vid_blank
);

    cpu_bus_t bus;
    owner_e   owner;
    logic     disrupt;

    assign bus = '{req: cpu_req, hit: cpu_hit, we: cpu_we};

    dra_owner_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .char_tick  (char_tick),
        .vid_window (vid_window),
        .bus        (bus),
        .owner      (owner)
    );

    dra_cpu_gate u_gate (
        .owner        (owner),
        .bus          (bus),
        .vid_window   (vid_window),
        .addr_sel_cpu (addr_sel_cpu),
        .cpu_ack      (cpu_ack),
        .cpu_wait     (cpu_wait),
        .ram_we       (ram_we),
        .disrupt      (disrupt)
    );

    dra_blank_hold #(.RECOVER_TICKS(RECOVER_TICKS)) u_blank (
        .clk       (clk),
        .rst       (rst),
        .char_tick (char_tick),
        .disrupt   (disrupt),
        .vid_blank (vid_blank)
    );

    a_r10_blank_disrupt: assert property (@(posedge clk) disable iff (rst)
        (!addr_sel_cpu == 1'b0 && cpu_ack && cpu_hit && vid_window) |-> vid_blank);

    a_r12_sel_free: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && cpu_hit) |-> addr_sel_cpu);

endmodule

// File: tb/shared_ram_arbiter_test.sv
module shared_ram_arbiter_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic char_tick = 1'b0;
    logic vid_window = 1'b0;
    logic cpu_req = 1'b0;
    logic cpu_hit = 1'b0;
    logic cpu_we = 1'b0;
    logic addr_sel_cpu, cpu_ack, cpu_wait, ram_we, vid_blank;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    shared_ram_arbiter uut (
        .clk(clk), .rst(rst), .char_tick(char_tick), .vid_window(vid_window),
        .cpu_req(cpu_req), .cpu_hit(cpu_hit), .cpu_we(cpu_we),
        .addr_sel_cpu(addr_sel_cpu), .cpu_ack(cpu_ack), .cpu_wait(cpu_wait),
        .ram_we(ram_we), .vid_blank(vid_blank)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // one clock, optionally a character tick; sample 1 ns after the edge
    task automatic cyc(input logic t);
        char_tick = t;
        @(posedge clk);
        #1;
        char_tick = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        cyc(1'b0); cyc(1'b0);
        rst = 1'b0;
        cyc(1'b0);
        chk("R1 sel", addr_sel_cpu, 1'b1);
        chk("R1 ack", cpu_ack, 1'b0);
        chk("R1 wait", cpu_wait, 1'b0);
        chk("R1 we", ram_we, 1'b0);
        chk("R1 blank", vid_blank, 1'b0);
    endtask

    task automatic t_free_grant;
        cpu_req = 1; cpu_hit = 1; cpu_we = 1; vid_window = 0;
        #0;
        chk("R9 we before grant", ram_we, 1'b0);
        cyc(1'b0);
        chk("R3 still waiting", cpu_wait, 1'b1);
        chk("R3 no ack", cpu_ack, 1'b0);
        cyc(1'b1);
        chk("R2 ack", cpu_ack, 1'b1);
        chk("R2 wait", cpu_wait, 1'b0);
        chk("R9 we owned", ram_we, 1'b1);
        chk("R12 sel", addr_sel_cpu, 1'b1);
        cpu_req = 0; cpu_we = 0;
        cyc(1'b1);
        chk("R12 sel free", addr_sel_cpu, 1'b1);
    endtask

    task automatic t_priority;
        cpu_req = 1; cpu_hit = 1; cpu_we = 1; vid_window = 1;
        cyc(1'b1);
        chk("R4 video owns", addr_sel_cpu, 1'b0);
        chk("R6 wait", cpu_wait, 1'b1);
        chk("R6 ack", cpu_ack, 1'b0);
        chk("R9 no we", ram_we, 1'b0);
        chk("R10 no blank", vid_blank, 1'b0);
        cyc(1'b1); cyc(1'b0);
        chk("R6 still locked", addr_sel_cpu, 1'b0);
        vid_window = 0;
        cyc(1'b0);
        chk("R3 no tick no handover", cpu_wait, 1'b1);
        cyc(1'b1);
        chk("R7 handover ack", cpu_ack, 1'b1);
        chk("R7 sel", addr_sel_cpu, 1'b1);
        cpu_req = 0; cpu_we = 0;
        cyc(1'b1);
    endtask

    task automatic t_no_abort;
        cpu_req = 1; cpu_hit = 1; vid_window = 0;
        cyc(1'b1);
        vid_window = 1;
        #0;
        chk("R10 blank while display waits", vid_blank, 1'b1);
        cyc(1'b1);
        chk("R5 kept", addr_sel_cpu, 1'b1);
        chk("R5 ack kept", cpu_ack, 1'b1);
        cpu_req = 0;
        cyc(1'b1);
        chk("R6 video takes", addr_sel_cpu, 1'b0);
        chk("R11 hold 2", vid_blank, 1'b1);
        cpu_req = 1;
        #0;
        chk("R6 lockout wait", cpu_wait, 1'b1);
        cyc(1'b0);
        chk("R11 no tick no count", vid_blank, 1'b1);
        cyc(1'b1);
        chk("R11 hold 1", vid_blank, 1'b1);
        cyc(1'b1);
        chk("R11 released", vid_blank, 1'b0);
        chk("R6 still video", addr_sel_cpu, 1'b0);
        vid_window = 0;
        cyc(1'b1);
        chk("R7 grant after window", cpu_ack, 1'b1);
        cpu_req = 0;
        cyc(1'b1);
    endtask

    task automatic t_outside;
        vid_window = 1;
        cyc(1'b1);
        cpu_req = 1; cpu_hit = 0; cpu_we = 1;
        #0;
        chk("R8 ack outside", cpu_ack, 1'b1);
        chk("R8 no wait", cpu_wait, 1'b0);
        chk("R9 no we outside", ram_we, 1'b0);
        cyc(1'b1);
        chk("R8 no ownership", addr_sel_cpu, 1'b0);
        chk("R8 no blank", vid_blank, 1'b0);
        cpu_req = 0; cpu_we = 0; vid_window = 0;
        cyc(1'b1);
        chk("R12 back to free", addr_sel_cpu, 1'b1);
    endtask

    initial begin
        #1;
        t_reset();
        t_free_grant();
        t_priority();
        t_no_abort();
        t_outside();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule